// File: doc/BRIEF.md
# IR Run-Length Receive Sampler

This block watches a demodulated infrared receiver line and reduces it to run-length bytes. The line is synchronised into the clock domain. It is then sampled once every programmable number of base-unit ticks. Each stretch of constant level is counted in sample periods and, when the level changes, is written to an eight-byte sample buffer as one byte. The byte carries the count and a flag that tells a space from a pulse.

The buffer is handed to software in two four-byte halves. A write-half flag shows which half the hardware is filling. When a half fills, the RX interrupt status bit is raised, and the half the hardware moves into is cleared to zero, because a zero byte marks space that holds no sample. A configuration write sets the sample period and selects whether long runs are split into full-scale entries. Dropping the receive enable returns the sampler to idle, where it waits for the first pulse.

Top module: `ir_rle_sampler`

## Requirements
- R1: After reset all eight buffer bytes read zero, wr_half is 0 and rx_irq is 0.
- R2: The IR level passes through a two-flop synchroniser. While rx_en is high, one sample is taken for every PERIOD assertions of tick. With tick low, no sample is taken and the buffer does not change.
- R3: An entry byte has bit 7 set when the run was a space (ir_in low) and clear when it was a pulse (ir_in high). Bits 6:0 hold the run length in samples. A run of N samples (N up to 127) is written at the first sample of the opposite level.
- R4: After enable or restart the sampler is idle. Samples of space level are ignored until the first pulse sample, which starts a run of length 1.
- R5: With the overflow bit (cfg_data bit 7) set, the 128th consecutive sample of one level writes an entry with count 127 and the run continues at length 1. A long run therefore yields repeated full-scale entries.
- R6: With the overflow bit clear, a run longer than 127 samples holds at 127 and produces a single entry of count 127 when the level changes.
- R7: Entries are written at indexes 0 through 7 in order and wrap from 7 to 0. wr_half equals bit 2 of the next write index. Entry i appears at buf_flat[8*i+7:8*i].
- R8: Writing the last byte of a half sets rx_irq and, on the same edge, clears all four bytes of the other half to zero.
- R9: A one-cycle pulse on irq_clr clears rx_irq, unless a half completes on the same edge.
- R10: A configuration write loads the sample period from cfg_data bits 6:0 and the overflow enable from bit 7. A period below 5 is replaced by the default of 50 ticks. The default after reset is 50 ticks with overflow enabled.
- R11: While rx_en is low the buffer reads zero, wr_half is 0, the run state is idle and the tick prescaler is cleared. rx_irq is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Base-unit tick enable |
| ir_in | input | 1 | Demodulated IR level, high = pulse |
| rx_en | input | 1 | Receive enable; low restarts to idle |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 8 | Bit 7 overflow enable, bits 6:0 sample period |
| irq_clr | input | 1 | Writes the RX interrupt status to zero |
| buf_flat | output | 64 | Eight sample bytes, entry i at bits 8i+7:8i |
| wr_half | output | 1 | Half currently being written |
| rx_irq | output | 1 | RX interrupt status |

## Verification
A level on ir_in reaches the sampling point two clock edges after it changes. The bench therefore sets the level and waits three clock cycles before it issues any tick. An entry is written on the same edge that takes the PERIOD-th tick of the sample that closes the run. rx_irq, wr_half and the cleared half change on that same edge, and irq_clr and rx_en act on the next edge. The bench drives ticks itself, one per cycle, so it knows which edge finishes each sample. It compares the whole buffer, the half flag and the interrupt bit on the falling edge after the last tick of each run, and after the edge that follows each acknowledge or enable change.

// File: rtl/ir_rle_sampler.sv
module ir_rle_sampler #(
  parameter int DEF_PERIOD = 50,
  parameter int MIN_PERIOD = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        ir_in,
  input  logic        rx_en,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_data,
  input  logic        irq_clr,
  output logic [63:0] buf_flat,
  output logic        wr_half,
  output logic        rx_irq
);
  localparam int NB = 8;
  localparam int CW = 7;
  localparam logic [CW-1:0] CMAX = '1;

  logic [1:0]    sync_q;
  logic [CW-1:0] period, pcnt, run_cnt;
  logic          ovf_en, act, run_lvl;
  logic [2:0]    wptr;
  logic [7:0]    mem [NB];

  wire lvl_s     = sync_q[1];
  wire strb      = rx_en && tick && (pcnt >= period - 1'b1);
  wire chg       = act && strb && (lvl_s != run_lvl);
  wire sat       = act && strb && !chg && (run_cnt == CMAX);
  wire emit      = chg || (sat && ovf_en);
  wire [7:0] eb  = {~run_lvl, run_cnt};
  wire half_done = emit && (wptr[1:0] == 2'd3);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], ir_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      period <= CW'(DEF_PERIOD);
      ovf_en <= 1'b1;
    end else if (cfg_wr) begin
      period <= (cfg_data[6:0] < CW'(MIN_PERIOD)) ? CW'(DEF_PERIOD) : cfg_data[6:0];
      ovf_en <= cfg_data[7];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                pcnt <= '0;
    else if (!rx_en || cfg_wr) pcnt <= '0;
    else if (strb)             pcnt <= '0;
    else if (tick)             pcnt <= pcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act <= 1'b0; run_lvl <= 1'b0; run_cnt <= '0;
    end else if (!rx_en) begin
      act <= 1'b0; run_lvl <= 1'b0; run_cnt <= '0;
    end else if (strb) begin
      if (!act) begin
        if (lvl_s) begin
          act <= 1'b1; run_lvl <= 1'b1; run_cnt <= CW'(1);
        end
      end else if (chg) begin
        run_lvl <= lvl_s; run_cnt <= CW'(1);
      end else if (run_cnt == CMAX) begin
        if (ovf_en) run_cnt <= CW'(1);
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr <= '0;
      for (int i = 0; i < NB; i++) mem[i] <= '0;
    end else if (!rx_en) begin
      wptr <= '0;
      for (int i = 0; i < NB; i++) mem[i] <= '0;
    end else if (emit) begin
      mem[wptr] <= eb;
      wptr <= wptr + 1'b1;
      if (half_done)
        for (int i = 0; i < NB/2; i++) mem[{~wptr[2], 2'(i)}] <= '0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         rx_irq <= 1'b0;
    else if (half_done) rx_irq <= 1'b1;
    else if (irq_clr)   rx_irq <= 1'b0;

  always_comb
    for (int i = 0; i < NB; i++) buf_flat[8*i +: 8] = mem[i];

  assign wr_half = wptr[2];

  // R3
  entry_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> eb[6:0] != '0);

  // R7
  wptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && rx_en) |=> wptr == $past(wptr) + 3'd1);

  // R8
  half_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_done |=> (rx_irq && wptr[1:0] == 2'd0));

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !half_done) |=> !rx_irq);

  // R11
  restart_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (wptr == '0 && !act && pcnt == '0));
endmodule

// File: tb/ir_rle_sampler_tb.sv
module ir_rle_sampler_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, ir_in = 1'b0;
  logic        rx_en = 1'b0, cfg_wr = 1'b0, irq_clr = 1'b0;
  logic [7:0]  cfg_data = '0;
  logic [63:0] buf_flat;
  logic        wr_half, rx_irq;

  int errors = 0, checks = 0, per = 50;
  logic       m_act, m_lvl, m_irq, m_ovf;
  logic [6:0] m_cnt;
  logic [2:0] m_wp;
  logic [7:0] m_buf [8];

  always #5 clk = ~clk;

  ir_rle_sampler dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .ir_in(ir_in),
    .rx_en(rx_en), .cfg_wr(cfg_wr), .cfg_data(cfg_data), .irq_clr(irq_clr),
    .buf_flat(buf_flat), .wr_half(wr_half), .rx_irq(rx_irq));

  task automatic chk(input string req, input logic [63:0] act_v, input logic [63:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  function automatic logic [63:0] m_flat();
    logic [63:0] f;
    for (int i = 0; i < 8; i++) f[8*i +: 8] = m_buf[i];
    return f;
  endfunction

  task automatic check_all(input string req);
    chk({req, " buffer"}, buf_flat, m_flat());
    chk({req, " wr_half"}, {63'd0, wr_half}, {63'd0, m_wp[2]});
    chk({req, " rx_irq"}, {63'd0, rx_irq}, {63'd0, m_irq});
  endtask

  task automatic m_restart();
    m_act = 0; m_lvl = 0; m_cnt = 0; m_wp = 0;
    for (int i = 0; i < 8; i++) m_buf[i] = 0;
  endtask

  task automatic m_emit(input logic [7:0] b);
    m_buf[m_wp] = b;
    if (m_wp[1:0] == 2'd3) begin
      m_irq = 1;
      for (int i = 0; i < 4; i++) m_buf[{~m_wp[2], 2'(i)}] = 0;
    end
    m_wp = m_wp + 3'd1;
  endtask

  task automatic m_sample(input logic l);
    if (!m_act) begin
      if (l) begin m_act = 1; m_lvl = 1; m_cnt = 1; end
    end else if (l != m_lvl) begin
      m_emit({~m_lvl, m_cnt}); m_lvl = l; m_cnt = 1;
    end else if (m_cnt == 7'd127) begin
      if (m_ovf) begin m_emit({~m_lvl, 7'd127}); m_cnt = 1; end
    end else m_cnt = m_cnt + 7'd1;
  endtask

  task automatic smp(input logic l, input int n);
    ir_in = l;
    repeat (3) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      for (int t = 0; t < per; t++) begin tick = 1; @(negedge clk); end
      tick = 0;
      m_sample(l);
    end
  endtask

  task automatic cfg(input logic [7:0] d);
    cfg_data = d; cfg_wr = 1; @(negedge clk); cfg_wr = 0;
    m_ovf = d[7];
    per = (d[6:0] < 5) ? 50 : int'(d[6:0]);
  endtask

  task automatic ack(input string req);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    m_irq = 0;
    chk(req, {63'd0, rx_irq}, 64'd0);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_restart(); m_irq = 0; m_ovf = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");

    cfg(8'h85); rx_en = 1; @(negedge clk);
    smp(1'b0, 3);
    check_all("R4 idle ignores space");
    ir_in = 1; repeat (20) @(negedge clk);
    check_all("R2 no tick no sample");

    smp(1, 3); smp(0, 2); smp(1, 1);
    check_all("R3 pulse/space entries");
    chk("R3 first entry", {56'd0, buf_flat[7:0]}, 64'h03);
    chk("R3 space flag", {56'd0, buf_flat[15:8]}, 64'h82);
    smp(0, 4); smp(1, 1);
    check_all("R8 half complete");
    chk("R8 irq set", {63'd0, rx_irq}, 64'd1);
    chk("R7 wr_half", {63'd0, wr_half}, 64'd1);
    ack("R9 ack clears irq");

    smp(0, 300);
    check_all("R5 full-scale entries");
    smp(1, 2);
    check_all("R5 remainder entry");
    if (m_irq) ack("R9 ack");

    cfg(8'h05);
    smp(0, 200); smp(1, 1);
    check_all("R6 saturate single entry");
    if (m_irq) ack("R9 ack");

    rx_en = 0; @(negedge clk);
    m_restart();
    check_all("R11 restart clears");
    rx_en = 1; @(negedge clk);

    cfg(8'h83);
    smp(0, 2); smp(1, 2); smp(0, 1);
    check_all("R10 default period");
    chk("R10 entry", {56'd0, buf_flat[7:0]}, 64'h02);

    cfg(8'h85);
    for (int r = 0; r < 40; r++) begin
      int n = (($urandom % 8) == 0) ? 130 + int'($urandom % 40) : 1 + int'($urandom % 20);
      smp(~m_lvl | ~m_act, n);
      check_all("R7 random runs");
      if (m_irq && ($urandom % 2)) ack("R9 random ack");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule